// File: doc/BRIEF.md
# Infrared Wake Pattern Matcher

This block watches the stream of run-length samples produced by an infrared sampling front end and compares it against a reference sequence that the host has loaded. Each sample is one byte. Bit 7 is set for a pulse (carrier present) and clear for a space. Bits 6..0 give the duration as a count of sample periods. When enough consecutive samples agree with the stored reference, the block raises a one-clock wake strobe. A sample "agrees" when it has the same polarity and a close enough length. A set number of disagreeing samples is allowed through a tolerance count.

The host reaches the block through a small byte-wide register port. To set up matching, the host enters learning mode and sets the load-enable bit. It then pushes the reference entries, starting with a pulse and alternating polarity. Next it programs how many entries take part (the depth) and how many mismatches are allowed (normally the depth divided by ten, rounded up). Finally it returns to compare mode. Stored entries can be read back through an index register and a data window, and reading them does not disturb an ongoing compare.

Top module: `irwake_matcher`

## Requirements
- R1: After a synchronous active-low reset the stored-entry count is 0, the control register reads 0 and `wake` is low.
- R2: A write to the reference data port (address 3) appends the byte at the position given by the current count and increments the count, but only while the load-enable bit (control bit 1) is 1. Otherwise the write is ignored. Writes once the count equals the capacity `MAX_ENTRIES` are also ignored.
- R3: Writing control with bit 2 set empties the stored entries (count becomes 0), but only if the learn bit (control bit 0) was already 1 before that write. Otherwise the stored entries are unchanged.
- R4: Reads return control at address 0 (bit 0 learn, bit 1 load-enable), depth at address 1, tolerance at address 2, count at 3, the read-back index at 4, and at address 5 the stored entry at that index. Setting the index or reading entries does not alter the outcome of a compare.
- R5: An incoming sample is a mismatch against its reference entry when bit 7 differs, or when the absolute difference of bits 6..0 exceeds the reference length shifted right by 3 (one eighth, rounded down).
- R6: Comparison runs only while the learn bit is 0 and the depth is between 1 and the count. Samples received at any other time produce no wake.
- R7: A compare starts at entry 0. The wake output is high for the single clock after the sample that completes `depth` compared samples with a total mismatch count no greater than the tolerance (address 2). The compare then restarts at entry 0.
- R8: When the running mismatch count exceeds the tolerance, the compare is abandoned and restarts at entry 0. At entry 0 only a pulse sample begins a compare; space samples there are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| smp_valid | input | 1 | Incoming sample strobe from the sampler |
| smp_data | input | 8 | Incoming sample: bit 7 pulse, bits 6..0 length |
| wake | output | 1 | One-clock wake strobe on a pattern match |

## Verification
The matcher is driven with several patterns. An exact copy of the reference must wake. A copy with one length error must still wake under a tolerance of one. A copy with a length error and then a polarity error must not wake, and must recover on the next clean copy. A copy preceded by stray spaces must wake, because those spaces are dropped at entry 0. Lengths exactly one eighth away from the reference and one step beyond show where the length window ends. The same clean pattern sent in learning mode, or with a depth larger than the stored count, shows the enable conditions. Pushing past capacity and issuing a clear in each mode shows the limits on storage and on clearing.

// File: rtl/irw_pkg.sv
// Shared constants and types for the infrared wake pattern matcher.
// Assumes a byte-wide host register port and byte samples.
package irw_pkg;
    localparam int SMP_W = 8;
    localparam int LEN_W = SMP_W - 1;

    // Host register addresses
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_DEPTH = 3'd1;
    localparam logic [2:0] A_TOL   = 3'd2;
    localparam logic [2:0] A_DATA  = 3'd3; // write: push entry, read: count
    localparam logic [2:0] A_IDX   = 3'd4;
    localparam logic [2:0] A_PEEK  = 3'd5;

    // Control bit positions
    localparam int C_LEARN = 0;
    localparam int C_LOAD  = 1;
    localparam int C_CLEAR = 2;

    typedef struct packed {
        logic             pulse;
        logic [LEN_W-1:0] len;
    } smp_t;
endpackage

// File: rtl/irw_ref_store.sv
// Reference entry storage: append-only array with a count, a clear,
// and two asynchronous read ports (one for the compare, one for read-back).
// Assumes push and clear never arrive in the same cycle.
module irw_ref_store
    import irw_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    localparam int IDX_W = $clog2(MAX_ENTRIES),
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SMP_W-1:0] push_data,
    input  logic             clear,
    input  logic [IDX_W-1:0] cmp_idx,
    output logic [SMP_W-1:0] cmp_entry,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [SMP_W-1:0] peek_entry,
    output logic [CNT_W-1:0] count
);
    logic [SMP_W-1:0] mem [MAX_ENTRIES];
    logic             full;

    assign full = (count == CNT_W'(MAX_ENTRIES));

    // Track the number of stored entries
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + 1'b1;
        end
    end

    // Write the pushed entry at the current tail
    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            mem[IDX_W'(count)] <= push_data;
        end
    end

    assign cmp_entry  = mem[cmp_idx];
    assign peek_entry = mem[peek_idx];
endmodule

// File: rtl/irw_sample_cmp.sv
// Decides whether one incoming sample disagrees with one reference entry:
// polarity must match and the length must lie within one eighth of the
// reference length. Purely combinational.
module irw_sample_cmp
    import irw_pkg::*;
(
    input  smp_t sample,
    input  smp_t ref_entry,
    output logic mismatch
);
    logic [LEN_W-1:0] diff;
    logic [LEN_W-1:0] window;

    // Absolute length difference and permitted window
    always_comb begin
        diff     = (sample.len > ref_entry.len) ? (sample.len - ref_entry.len)
                                                : (ref_entry.len - sample.len);
        window   = ref_entry.len >> 3;
        mismatch = (sample.pulse != ref_entry.pulse) || (diff > window);
    end
endmodule

// File: rtl/irw_seq_tracker.sv
// Walks the reference sequence one sample at a time, accumulating
// mismatches, and emits a one-clock wake on a tolerated full match.
// Assumes depth never exceeds the stored count while enabled.
module irw_seq_tracker
    import irw_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic             smp_pulse,
    input  logic             mismatch,
    input  logic [7:0]       depth,
    input  logic [7:0]       tol,
    output logic [IDX_W-1:0] pos,
    output logic             wake
);
    logic [7:0] err;
    logic [7:0] err_next;
    logic       at_last;
    logic       idle_space;

    // Next error count and end-of-sequence detection
    always_comb begin
        err_next   = err + {7'd0, mismatch};
        at_last    = ((8'(pos) + 8'd1) == depth);
        idle_space = (pos == '0) && !smp_pulse;
    end

    // Sequence position, error count and wake strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pos  <= '0;
            err  <= '0;
            wake <= 1'b0;
        end else begin
            wake <= 1'b0;
            if (smp_valid && !idle_space) begin
                if (err_next > tol) begin
                    pos <= '0;
                    err <= '0;
                end else if (at_last) begin
                    wake <= 1'b1;
                    pos  <= '0;
                    err  <= '0;
                end else begin
                    pos <= pos + 1'b1;
                    err <= err_next;
                end
            end
        end
    end
endmodule

// File: rtl/irwake_matcher.sv
// Top of the infrared wake pattern matcher: host register file, reference
// storage, per-sample comparator and sequence tracker.
// Assumes samples arrive already run-length encoded from a shared sampler.
module irwake_matcher
    import irw_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    localparam int IDX_W = $clog2(MAX_ENTRIES),
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       smp_valid,
    input  logic [7:0] smp_data,
    output logic       wake
);
    logic             learn_q;
    logic             load_q;
    logic [7:0]       depth_q;
    logic [7:0]       tol_q;
    logic [IDX_W-1:0] idx_q;
    logic             push;
    logic             clear;
    logic             cmp_en;
    logic [IDX_W-1:0] pos;
    logic [SMP_W-1:0] cmp_entry;
    logic [SMP_W-1:0] peek_entry;
    logic [CNT_W-1:0] ref_count;
    logic             mismatch;

    // Host writes to the control, depth, tolerance and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            learn_q <= 1'b0;
            load_q  <= 1'b0;
            depth_q <= '0;
            tol_q   <= '0;
            idx_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    learn_q <= wr_data[C_LEARN];
                    load_q  <= wr_data[C_LOAD];
                end
                A_DEPTH: depth_q <= wr_data;
                A_TOL:   tol_q   <= wr_data;
                A_IDX:   idx_q   <= wr_data[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    // Gated push and clear strobes toward the storage
    always_comb begin
        push  = wr_en && (wr_addr == A_DATA) && load_q;
        clear = wr_en && (wr_addr == A_CTRL) && wr_data[C_CLEAR] && learn_q;
    end

    // Compare runs in compare mode with a usable depth
    assign cmp_en = !learn_q && (depth_q != 8'd0) &&
                    ({{(8-CNT_W){1'b0}}, ref_count} >= depth_q);

    irw_ref_store #(.MAX_ENTRIES(MAX_ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (wr_data),
        .clear      (clear),
        .cmp_idx    (pos),
        .cmp_entry  (cmp_entry),
        .peek_idx   (idx_q),
        .peek_entry (peek_entry),
        .count      (ref_count)
    );

    irw_sample_cmp u_cmp (
        .sample    (smp_t'(smp_data)),
        .ref_entry (smp_t'(cmp_entry)),
        .mismatch  (mismatch)
    );

    irw_seq_tracker #(.IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cmp_en),
        .smp_valid (smp_valid),
        .smp_pulse (smp_data[SMP_W-1]),
        .mismatch  (mismatch),
        .depth     (depth_q),
        .tol       (tol_q),
        .pos       (pos),
        .wake      (wake)
    );

    // Host read multiplexer
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {6'd0, load_q, learn_q};
            A_DEPTH: rd_data = depth_q;
            A_TOL:   rd_data = tol_q;
            A_DATA:  rd_data = 8'(ref_count);
            A_IDX:   rd_data = 8'(idx_q);
            A_PEEK:  rd_data = peek_entry;
            default: rd_data = 8'd0;
        endcase
    end
endmodule

// File: rtl/irw_checker.sv
// Assertion checker for irwake_matcher, attached by bind.
module irw_checker
    import irw_pkg::*;
#(
    parameter int MAX_ENTRIES = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             smp_valid,
    input logic             learn_q,
    input logic             load_q,
    input logic [7:0]       depth_q,
    input logic [CNT_W-1:0] ref_count,
    input logic             wake
);
    // R2: data writes without load-enable leave the count alone
    assert_load_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DATA && !load_q) |=> $stable(ref_count));

    // R2: the count never exceeds capacity
    assert_capacity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_count <= CNT_W'(MAX_ENTRIES));

    // R3: a clear request outside learning mode has no effect
    assert_clear_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && wr_data[C_CLEAR] && !learn_q)
        |=> $stable(ref_count));

    // R6: no wake while learning mode has been held
    assert_learn_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(learn_q) && learn_q) |-> !wake);

    // R6: a wake needs a nonzero depth on the preceding cycle
    assert_depth_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(depth_q) != 8'd0));

    // R7: a wake always follows a sample
    assert_wake_after_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(smp_valid));
endmodule

bind irwake_matcher irw_checker #(.MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .smp_valid (smp_valid),
    .learn_q   (learn_q),
    .load_q    (load_q),
    .depth_q   (depth_q),
    .ref_count (ref_count),
    .wake      (wake)
);

// File: tb/irwake_matcher_bench.sv
// Directed bench for irwake_matcher: one task per scenario.
module irwake_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       wake;

    int vectors = 0;
    int errors  = 0;
    int wake_cnt = 0;
    bit finished = 0;

    logic [7:0] pat [6];

    irwake_matcher #(.MAX_ENTRIES(CAP)) u_irwake_matcher (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .smp_valid(smp_valid), .smp_data(smp_data), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count wake strobes seen at the output
    always @(posedge clk) if (rst_n && wake === 1'b1) wake_cnt++;

    task automatic check(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic smp(logic [7:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_pat();
        for (int i = 0; i < 6; i++) smp(pat[i]);
        @(negedge clk);
    endtask

    task automatic rearm();
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
        wake_cnt = 0;
    endtask

    task automatic t_reset();
        int v;
        rd(3'd3, v); check("R1 count", v, 0);
        rd(3'd0, v); check("R1 ctrl", v, 0);
        check("R1 wake", int'(wake), 0);
    endtask

    task automatic t_load();
        int v;
        wr(3'd0, 8'h01);            // learn, load disabled
        wr(3'd3, 8'h94);
        rd(3'd3, v); check("R2 push ignored without load", v, 0);
        wr(3'd0, 8'h03);            // learn + load
        for (int i = 0; i < 6; i++) wr(3'd3, pat[i]);
        rd(3'd3, v); check("R2 count after load", v, 6);
        wr(3'd0, 8'h01);
        wr(3'd1, 8'd6);
        wr(3'd2, 8'd1);
        rd(3'd1, v); check("R4 depth readback", v, 6);
        rd(3'd2, v); check("R4 tol readback", v, 1);
        wr(3'd4, 8'd2);
        rd(3'd5, v); check("R4 peek idx2", v, 'hA8);
        wr(3'd4, 8'd5);
        rd(3'd4, v); check("R4 idx readback", v, 5);
        rd(3'd5, v); check("R4 peek idx5", v, 'h1E);
    endtask

    task automatic t_exact();
        rearm();
        send_pat();
        check("R7 exact match wakes once", wake_cnt, 1);
        check("R4 peek does not disturb compare", wake_cnt, 1);
    endtask

    task automatic t_one_err();
        rearm();
        smp(8'h94); smp(8'h0C); smp(8'hA8); smp(8'h0A); smp(8'h94); smp(8'h1E);
        @(negedge clk);
        check("R7 one length error within tol wakes", wake_cnt, 1);
    endtask

    task automatic t_over_tol();
        rearm();
        smp(8'h94); smp(8'h1E); smp(8'hA8); smp(8'h8A);
        @(negedge clk);
        check("R8 two errors give no wake", wake_cnt, 0);
        send_pat();
        check("R8 restart then clean pattern wakes", wake_cnt, 1);
    endtask

    task automatic t_lead_space();
        rearm();
        smp(8'h0A); smp(8'h14);
        send_pat();
        check("R8 leading spaces dropped at entry 0", wake_cnt, 1);
    endtask

    task automatic t_window();
        wr(3'd2, 8'd0);
        rearm();
        smp(8'h94); smp(8'h0A); smp(8'hAD); smp(8'h0A); smp(8'h94); smp(8'h1E);
        @(negedge clk);
        check("R5 length at one eighth matches", wake_cnt, 1);
        rearm();
        smp(8'h94); smp(8'h0A); smp(8'hAE); smp(8'h0A); smp(8'h94); smp(8'h1E);
        @(negedge clk);
        check("R5 length beyond one eighth mismatches", wake_cnt, 0);
        rearm();
        smp(8'h94); smp(8'h8A); smp(8'hA8); smp(8'h0A); smp(8'h94); smp(8'h1E);
        @(negedge clk);
        check("R5 polarity difference mismatches", wake_cnt, 0);
        wr(3'd2, 8'd1);
    endtask

    task automatic t_enable();
        wr(3'd0, 8'h01);
        wake_cnt = 0;
        send_pat();
        check("R6 no wake in learning mode", wake_cnt, 0);
        wr(3'd1, 8'd10);
        rearm();
        send_pat();
        check("R6 no wake when depth exceeds count", wake_cnt, 0);
        wr(3'd1, 8'd6);
    endtask

    task automatic t_clear();
        int v;
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h04);            // clear while in compare mode
        rd(3'd3, v); check("R3 clear ignored in compare mode", v, 6);
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h05);
        rd(3'd3, v); check("R3 clear in learning mode", v, 0);
        wr(3'd0, 8'h03);
        for (int i = 0; i < CAP + 2; i++) wr(3'd3, 8'h81);
        rd(3'd3, v); check("R2 count saturates at capacity", v, CAP);
    endtask

    initial begin
        pat[0] = 8'h94; pat[1] = 8'h0A; pat[2] = 8'hA8;
        pat[3] = 8'h0A; pat[4] = 8'h94; pat[5] = 8'h1E;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_exact();
        t_one_err();
        t_over_tol();
        t_lead_space();
        t_window();
        t_enable();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule